// File: doc/BRIEF.md
# Buffered BCD Calendar Clock Registers

This block keeps calendar time in a chain of BCD counters: seconds, minutes, hours, weekday, day of month, month, two-digit year and century. A one-cycle strobe from an external prescaler advances the chain once per second. Software never reads these live counters directly. It reads and writes a separate bank of user registers at the top of a 32K-byte address space. That bank takes a fresh copy of the whole counter chain, all fields at once, in the cycle after each second step.

Two control bits change how the bank and the counters interact. The freeze bit stops the copying, so a multi-byte read sees one consistent instant while the chain keeps counting. The set bit also stops the copying, and while it is set software fills the user registers with a new time. Clearing the set bit moves every field, century included, into the live counters in a single cycle. A run-stop bit in the seconds byte gates the one-second strobe.

The port is a synchronous byte bus. A read returns registered data one cycle after the request.

Top module: `rtc_calendar_regs`

## Requirements
- R1: With ADDR_W = 15, the control byte sits at 7FF8h, seconds at 7FF9h, minutes at 7FFAh, hours at 7FFBh, weekday at 7FFCh, day of month at 7FFDh, month at 7FFEh, year at 7FFFh and century at 7FF1h. All are BCD. In the control byte, bit 7 is the set bit, bit 6 is the freeze bit, and bits 5..0 read as 0.
- R2: On each accepted step, seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and advance both the weekday and the day of month. The weekday counts 01 to 07 and then returns to 01.
- R3: The day of month wraps to 01 after 28, 29, 30 or 31, depending on the month. February has 29 days when the year is divisible by 4. For year 00, the test is instead whether the century value is divisible by 4, so 2000 is a leap year and 2100 is not.
- R4: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00 and advances the century.
- R5: In the cycle after each accepted step, all user time registers take the live counter values together.
- R6: While the freeze bit is 1, the user registers keep their contents and the live counters go on counting. After the bit is cleared, the registers change only at the next accepted step.
- R7: Setting freeze or set in the cycle right after a step does not block the copy that this step started.
- R8: While the set bit is 1, no copy takes place and writes go into the user registers. Writing 0 to the set bit while it is 1 loads every user time register, century included, into the live counters at that edge. A step that arrives in the same cycle is dropped.
- R9: Bit 7 of the seconds byte is a run-stop bit that reads back as written. While it is 1, the one-second strobe is ignored, and neither the counters nor the copy advance.
- R10: After reset, control reads 00h and the time reads 00:00:00, weekday 01, date 01, month 01, year 00, century 20.
- R11: Addresses 7FF2h to 7FF7h and 7FF0h read as 00h, and writes to them have no effect.
- R12: A read request returns its data with the valid flag exactly one cycle later. The valid flag stays low when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
The calendar chain is run from several loaded start points just before a boundary. These are a plain February in 2023, a leap February in 2024, the century years 2000 and 2100, and a year end in 2099. Together they separate the ordinary divisible-by-4 rule, the century rule for year 00, and the year-to-century carry. The buffering is tested with a frozen snapshot across several strobes, with a freeze written in the cycle after a strobe, and with a strobe that coincides with the load. These cases show apart a live chain that keeps counting, a copy that is already underway, and load priority. A stopped period followed by a restart shows that gated strobes are not counted.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] cent;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] day;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET_TIME = '{cent: 8'h20, yr: 8'h00, mon: 5'h01,
                                           date: 6'h01, day: 3'h1, hr: 6'h00,
                                           min: 7'h00, sec: 7'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction

  // tens*10 + ones is divisible by 4 when (2*tens + ones) is
  function automatic logic div_by_4(input logic [7:0] v);
    logic [1:0] s;
    s = {v[4], 1'b0} + v[1:0];
    return (s == 2'b00);
  endfunction

  function automatic logic leap_year(input logic [7:0] yr, input logic [7:0] cent);
    if (yr == 8'h00) return div_by_4(cent);
    return div_by_4(yr);
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02: return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default: return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);

  rtc_time_t cur_q, nxt;
  logic [5:0] last_day;

  always_comb begin
    last_day = month_len(cur_q.mon, leap_year(cur_q.yr, cur_q.cent));
    nxt = cur_q;
    if (load) begin
      nxt = load_val;
    end else if (step) begin
      if (cur_q.sec != 7'h59) begin
        nxt.sec = 7'(bcd_inc(8'(cur_q.sec)));
      end else begin
        nxt.sec = 7'h00;
        if (cur_q.min != 7'h59) begin
          nxt.min = 7'(bcd_inc(8'(cur_q.min)));
        end else begin
          nxt.min = 7'h00;
          if (cur_q.hr != 6'h23) begin
            nxt.hr = 6'(bcd_inc(8'(cur_q.hr)));
          end else begin
            nxt.hr  = 6'h00;
            nxt.day = (cur_q.day >= 3'h7) ? 3'h1 : cur_q.day + 3'h1;
            if (cur_q.date != last_day) begin
              nxt.date = 6'(bcd_inc(8'(cur_q.date)));
            end else begin
              nxt.date = 6'h01;
              if (cur_q.mon != 5'h12) begin
                nxt.mon = 5'(bcd_inc(8'(cur_q.mon)));
              end else begin
                nxt.mon = 5'h01;
                if (cur_q.yr != 8'h99) begin
                  nxt.yr = bcd_inc(cur_q.yr);
                end else begin
                  nxt.yr   = 8'h00;
                  nxt.cent = (cur_q.cent == 8'h99) ? 8'h00 : bcd_inc(cur_q.cent);
                end
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= RTC_RESET_TIME;
    else     cur_q <= nxt;
  end

  assign now = cur_q;

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !load && cur_q.sec == 7'h59) |=> (cur_q.sec == 7'h00));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(cur_q));

  assert_load_all_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_q == $past(load_val)));

endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  input  rtc_time_t         live,
  output logic [7:0]        rdata,
  output logic              rd_valid,
  output rtc_time_t         shadow,
  output logic              load,
  output logic              step
);

  localparam logic [ADDR_W-1:0] A_TOP  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_CTRL = A_TOP - ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_SEC  = A_TOP - ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_MIN  = A_TOP - ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_HR   = A_TOP - ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DAY  = A_TOP - ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DATE = A_TOP - ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MON  = A_TOP - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_YR   = A_TOP;
  localparam logic [ADDR_W-1:0] A_CENT = A_TOP - ADDR_W'(14);

  rtc_time_t shadow_q;
  logic set_q, freeze_q, stop_q, pend_q;
  logic ctrl_wr;
  logic [7:0] rd_mux, rdata_q;
  logic rvalid_q;

  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign load    = ctrl_wr && set_q && !wdata[7];
  assign step    = tick && !stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= RTC_RESET_TIME;
      set_q    <= 1'b0;
      freeze_q <= 1'b0;
      stop_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      // a step seen while no halt is set finishes its copy next cycle
      pend_q <= step && !set_q && !freeze_q;
      if (pend_q) shadow_q <= live;
      if (wr_en) begin
        case (addr)
          A_CTRL: begin set_q <= wdata[7]; freeze_q <= wdata[6]; end
          A_SEC:  begin shadow_q.sec <= wdata[6:0]; stop_q <= wdata[7]; end
          A_MIN:  shadow_q.min  <= wdata[6:0];
          A_HR:   shadow_q.hr   <= wdata[5:0];
          A_DAY:  shadow_q.day  <= wdata[2:0];
          A_DATE: shadow_q.date <= wdata[5:0];
          A_MON:  shadow_q.mon  <= wdata[4:0];
          A_YR:   shadow_q.yr   <= wdata;
          A_CENT: shadow_q.cent <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    case (addr)
      A_CTRL: rd_mux = {set_q, freeze_q, 6'b0};
      A_SEC:  rd_mux = {stop_q, shadow_q.sec};
      A_MIN:  rd_mux = {1'b0, shadow_q.min};
      A_HR:   rd_mux = {2'b0, shadow_q.hr};
      A_DAY:  rd_mux = {5'b0, shadow_q.day};
      A_DATE: rd_mux = {2'b0, shadow_q.date};
      A_MON:  rd_mux = {3'b0, shadow_q.mon};
      A_YR:   rd_mux = shadow_q.yr;
      A_CENT: rd_mux = shadow_q.cent;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= 8'h00;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rvalid_q;
  assign shadow   = shadow_q;

  assert_copy_together_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !wr_en) |=> (shadow_q == $past(live)));

  assert_freeze_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (freeze_q && !pend_q && !wr_en) |=> $stable(shadow_q));

  assert_rvalid_timing_R12: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid_q);

  assert_rvalid_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid_q);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr > A_CENT && addr < A_CTRL) |=> (rdata_q == 8'h00));

endmodule

// File: rtl/rtc_calendar_regs.sv
module rtc_calendar_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid
);

  rtc_time_t live_t, shadow_t;
  logic load_s, step_s;

  rtc_user_bank #(.ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rst(rst), .tick(tick_1hz),
    .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd), .wdata(bus_wdata),
    .live(live_t), .rdata(bus_rdata), .rd_valid(bus_rvalid),
    .shadow(shadow_t), .load(load_s), .step(step_s)
  );

  rtc_time_chain chain_i (
    .clk(clk), .rst(rst), .step(step_s), .load(load_s),
    .load_val(shadow_t), .now(live_t)
  );

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (load_s && step_s) |=> (live_t == $past(shadow_t)));

endmodule

// File: tb/rtc_calendar_regs_tb_top.sv
module rtc_calendar_regs_tb_top;

  localparam logic [14:0] A_CTRL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
                          A_HR = 15'h7FFB, A_DAY = 15'h7FFC, A_DATE = 15'h7FFD,
                          A_MON = 15'h7FFE, A_YR = 15'h7FFF, A_CENT = 15'h7FF1,
                          A_FLAG = 15'h7FF0, A_RSV = 15'h7FF4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1hz = 1'b0;
  logic [14:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic bus_rvalid;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rtc_calendar_regs #(.ADDR_W(15)) dut_i (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  // monitor: compares read results against queued expectations
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected valid: actual 1 expected 0");
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic tick();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] c, y, mo, dt, dy, h, mi, s);
    wr(A_CTRL, 8'h80);
    wr(A_CENT, c); wr(A_YR, y); wr(A_MON, mo); wr(A_DATE, dt);
    wr(A_DAY, dy); wr(A_HR, h); wr(A_MIN, mi); wr(A_SEC, s);
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state, R1 map
    rd(A_CTRL, 8'h00, "R10 ctrl");
    rd(A_SEC, 8'h00, "R10 sec");
    rd(A_DATE, 8'h01, "R10 date");
    rd(A_MON, 8'h01, "R10 month");
    rd(A_DAY, 8'h01, "R10 day");
    rd(A_CENT, 8'h20, "R10 R1 century");

    // R11 reserved and flags
    wr(A_RSV, 8'hFF);
    rd(A_RSV, 8'h00, "R11 reserved");
    wr(A_FLAG, 8'hFF);
    rd(A_FLAG, 8'h00, "R11 flags");

    // R2 R3 ordinary February, R5 copy after step
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h58);
    tick();
    rd(A_SEC, 8'h59, "R5 sec copy");
    tick();
    rd(A_SEC, 8'h00, "R2 sec wrap");
    rd(A_MIN, 8'h00, "R2 min wrap");
    rd(A_HR, 8'h00, "R2 hr wrap");
    rd(A_DAY, 8'h03, "R2 day");
    rd(A_DATE, 8'h01, "R3 2023 feb");
    rd(A_MON, 8'h03, "R3 month");

    // R3 leap 2024, weekday 7 -> 1
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
    tick();
    rd(A_DATE, 8'h29, "R3 2024 leap");
    rd(A_DAY, 8'h01, "R2 weekday wrap");

    // R3 century rule
    set_time(8'h21, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    rd(A_DATE, 8'h01, "R3 2100 not leap");
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick();
    rd(A_DATE, 8'h29, "R3 2000 leap");

    // R4 year end into century
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    tick();
    rd(A_YR, 8'h00, "R4 year wrap");
    rd(A_CENT, 8'h21, "R4 R8 century");
    rd(A_MON, 8'h01, "R4 month wrap");

    // R6 freeze: counters continue underneath
    set_time(8'h20, 8'h23, 8'h05, 8'h10, 8'h03, 8'h10, 8'h00, 8'h00);
    wr(A_CTRL, 8'h40);
    tick(); tick(); tick();
    rd(A_SEC, 8'h00, "R6 frozen");
    rd(A_CTRL, 8'h40, "R6 R1 ctrl bit");
    wr(A_CTRL, 8'h00);
    rd(A_SEC, 8'h00, "R6 no copy before step");
    tick();
    rd(A_SEC, 8'h04, "R6 counted through");

    // R7 halt right after a step keeps that copy
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    wr(A_CTRL, 8'h40);
    rd(A_SEC, 8'h05, "R7 copy completed");
    tick();
    rd(A_SEC, 8'h05, "R7 then frozen");
    wr(A_CTRL, 8'h00);

    // R8 set mode, load with coincident step
    wr(A_CTRL, 8'h80);
    wr(A_SEC, 8'h30);
    tick();
    rd(A_SEC, 8'h30, "R8 no copy while set");
    bus_addr = A_CTRL; bus_wdata = 8'h00; bus_wr = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_1hz = 1'b0;
    @(negedge clk);
    tick();
    rd(A_SEC, 8'h31, "R8 load wins over step");

    // R9 run-stop bit
    set_time(8'h20, 8'h23, 8'h05, 8'h10, 8'h03, 8'h10, 8'h00, 8'h95);
    rd(A_SEC, 8'h95, "R9 stop readback");
    tick(); tick();
    rd(A_SEC, 8'h95, "R9 stopped no copy");
    wr(A_SEC, 8'h15);
    tick();
    rd(A_SEC, 8'h16, "R9 stopped steps not counted");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0 || bus_rvalid !== 1'b0) begin
      errors++;
      $display("FAIL R12 pending reads: actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule